// File: doc/BRIEF.md
# Decode-Stage Branch Resolution Unit

This block settles conditional branches and jumps while they sit in the decode/register-read stage of a five-stage pipeline. A taken branch therefore costs a single lost fetch slot rather than waiting for execute or memory. The block owns a small fetch front end: the program counter and the fetch-to-decode instruction register. It decodes the instruction held in that register and sends out the index of its source register. The register value comes back as an operand, and the block tests it for zero. A dedicated adder forms the taken target. The unit then chooses the next fetch address.

A static configuration input selects what happens to the instruction fetched behind a taken branch. In squashing mode, fetch is speculatively sequential, and a redirect turns that successor into a no-op. In delay-slot mode, the successor always proceeds into decode, and the redirected fetch follows it. Operands arrive straight from the register file; results still in flight are not forwarded to the comparator.

Top module: `branch_resolve_unit`

## Requirements
- R1: While reset is asserted, the fetch address is RESET_PC (0x0000_1000 by default), the decode slot holds the all-zero no-op word and redirect is low.
- R2: In any cycle without a redirect, the fetch address advances by exactly 4 on the next clock.
- R3: A conditional branch has opcode 6'h01 in bits 31:26, and its source register index (bits 25:21) is driven on rs_idx. Sub-code 5'h00 in bits 20:16 is taken when the full operand is zero. Sub-code 5'h01 is taken when any operand bit is set.
- R4: A conditional branch target is the decode-stage PC+4 plus the sign-extended bits 15:0 shifted left by two. Backward offsets are included.
- R5: Opcode 6'h02 is an unconditional jump. Its target is the top four bits of the decode-stage PC+4, then bits 25:0, then two zero bits.
- R6: Redirect and target_pc are valid in the cycle the branch or jump is in decode. The next fetch address equals that target, so one sequential fetch slot is lost.
- R7: With delay_mode low, a redirect raises squash, and the decode slot becomes the all-zero no-op on the next clock.
- R8: With delay_mode high, squash never rises, and the instruction fetched behind a taken branch enters decode unchanged before the target.
- R9: Any other opcode, and a conditional branch opcode with a sub-code other than 5'h00 or 5'h01, never redirects and leaves fetch sequential.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| delay_mode | input | 1 | 0: squash the successor on redirect; 1: successor is an architectural delay slot |
| fetch_instr | input | 32 | Instruction word read at fetch_pc |
| rs_data | input | DATA_W | Register file value for rs_idx |
| fetch_pc | output | ADDR_W | Current fetch address |
| rs_idx | output | 5 | Source register index of the instruction in decode |
| redirect | output | 1 | Next fetch address is target_pc instead of fetch_pc+4 |
| target_pc | output | ADDR_W | Resolved branch or jump target |
| squash | output | 1 | The fetched successor is replaced by a no-op |
| id_instr | output | 32 | Instruction held in the decode stage |

## Verification
Each control-flow form is placed at one fixed program position and run in both modes, and the whole fetch address trace around it is compared with an expected sequence. The zero test is tried with an all-zero operand, a small value, an all-ones value and a value with only the top bit set. These operands show whether the test covers every bit and whether the two sub-codes are inverted correctly. A backward offset shows that the immediate is sign-extended, and a jump shows how its target field is concatenated. An unused sub-code and ordinary instructions show that nothing else redirects. The decode-slot contents after each redirect show whether the successor was squashed or kept as a delay slot.

// File: rtl/brr_pkg.sv
package brr_pkg;

  localparam int INSTR_W = 32;
  localparam int REGIDX_W = 5;
  localparam int IMM_W = 16;
  localparam int JFIELD_W = 26;

  localparam logic [5:0] OP_BCOND = 6'h01;
  localparam logic [5:0] OP_JUMP  = 6'h02;
  localparam logic [4:0] SUB_IFZERO    = 5'h00;
  localparam logic [4:0] SUB_IFNONZERO = 5'h01;

  localparam logic [INSTR_W-1:0] NOP_WORD = '0;

  typedef enum logic [1:0] {
    CTL_NONE,
    CTL_BR_ZERO,
    CTL_BR_NONZERO,
    CTL_JUMP
  } ctl_kind_t;

  function automatic ctl_kind_t classify(input logic [INSTR_W-1:0] w);
    ctl_kind_t k;
    k = CTL_NONE;
    if (w[31:26] == OP_JUMP) k = CTL_JUMP;
    else if (w[31:26] == OP_BCOND) begin
      if (w[20:16] == SUB_IFZERO) k = CTL_BR_ZERO;
      else if (w[20:16] == SUB_IFNONZERO) k = CTL_BR_NONZERO;
    end
    return k;
  endfunction

endpackage

// File: rtl/brr_decode.sv
module brr_decode
  import brr_pkg::*;
(
  input  logic [INSTR_W-1:0]  instr,
  output ctl_kind_t           kind,
  output logic [REGIDX_W-1:0] rs_idx,
  output logic [IMM_W-1:0]    imm,
  output logic [JFIELD_W-1:0] jfield
);

  always_comb begin
    kind   = classify(instr);
    rs_idx = instr[25:21];
    imm    = instr[15:0];
    jfield = instr[25:0];
  end

endmodule

// File: rtl/brr_resolve.sv
module brr_resolve
  import brr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  ctl_kind_t           kind,
  input  logic [DATA_W-1:0]   operand,
  input  logic [ADDR_W-1:0]   pc4,
  input  logic [IMM_W-1:0]    imm,
  input  logic [JFIELD_W-1:0] jfield,
  output logic                opnd_zero,
  output logic                taken,
  output logic [ADDR_W-1:0]   target
);

  localparam int EXT_W = ADDR_W - IMM_W - 2;
  localparam int JHI_W = ADDR_W - JFIELD_W - 2;

  function automatic logic [ADDR_W-1:0] word_offset(input logic [IMM_W-1:0] v);
    return {{EXT_W{v[IMM_W-1]}}, v, 2'b00};
  endfunction

  function automatic logic [ADDR_W-1:0] region_target(input logic [ADDR_W-1:0] p,
                                                      input logic [JFIELD_W-1:0] f);
    return {p[ADDR_W-1 -: JHI_W], f, 2'b00};
  endfunction

  logic [ADDR_W-1:0] br_target;
  logic [ADDR_W-1:0] jmp_target;

  always_comb begin
    opnd_zero  = (operand == '0);
    br_target  = pc4 + word_offset(imm);
    jmp_target = region_target(pc4, jfield);
    unique case (kind)
      CTL_BR_ZERO:    taken = opnd_zero;
      CTL_BR_NONZERO: taken = !opnd_zero;
      CTL_JUMP:       taken = 1'b1;
      default:        taken = 1'b0;
    endcase
    target = (kind == CTL_JUMP) ? jmp_target : br_target;
  end

endmodule

// File: rtl/brr_fetch.sv
module brr_fetch
  import brr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = 32'h0000_1000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [INSTR_W-1:0]  fetch_instr,
  input  logic                redirect,
  input  logic [ADDR_W-1:0]   target,
  input  logic                squash,
  output logic [ADDR_W-1:0]   fetch_pc,
  output logic [INSTR_W-1:0]  id_instr,
  output logic [ADDR_W-1:0]   id_pc4
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] seq_pc;
  logic [INSTR_W-1:0] ir_q;
  logic [ADDR_W-1:0] pc4_q;

  assign seq_pc = pc_q + STEP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= RESET_PC;
      ir_q  <= NOP_WORD;
      pc4_q <= RESET_PC;
    end else begin
      pc_q  <= redirect ? target : seq_pc;
      ir_q  <= squash ? NOP_WORD : fetch_instr;
      pc4_q <= seq_pc;
    end
  end

  assign fetch_pc = pc_q;
  assign id_instr = ir_q;
  assign id_pc4   = pc4_q;

endmodule

// File: rtl/branch_resolve_unit.sv
module branch_resolve_unit
  import brr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = 32'h0000_1000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                delay_mode,
  input  logic [31:0]         fetch_instr,
  input  logic [DATA_W-1:0]   rs_data,
  output logic [ADDR_W-1:0]   fetch_pc,
  output logic [4:0]          rs_idx,
  output logic                redirect,
  output logic [ADDR_W-1:0]   target_pc,
  output logic                squash,
  output logic [31:0]         id_instr
);

  ctl_kind_t           dec_kind;
  logic [IMM_W-1:0]    dec_imm;
  logic [JFIELD_W-1:0] dec_jfield;
  logic [ADDR_W-1:0]   id_pc4;
  logic                opnd_zero;
  logic                res_taken;
  logic [ADDR_W-1:0]   res_target;

  brr_fetch #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_fetch (
    .clk(clk), .rst_n(rst_n), .fetch_instr(fetch_instr),
    .redirect(res_taken), .target(res_target), .squash(squash),
    .fetch_pc(fetch_pc), .id_instr(id_instr), .id_pc4(id_pc4)
  );

  brr_decode u_decode (
    .instr(id_instr), .kind(dec_kind), .rs_idx(rs_idx),
    .imm(dec_imm), .jfield(dec_jfield)
  );

  brr_resolve #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_resolve (
    .kind(dec_kind), .operand(rs_data), .pc4(id_pc4), .imm(dec_imm),
    .jfield(dec_jfield), .opnd_zero(opnd_zero), .taken(res_taken),
    .target(res_target)
  );

  assign redirect  = res_taken;
  assign target_pc = res_target;
  assign squash    = res_taken && !delay_mode;

endmodule

// File: rtl/brr_checker.sv
module brr_checker
  import brr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              delay_mode,
  input logic [31:0]       fetch_instr,
  input logic [ADDR_W-1:0] fetch_pc,
  input logic              redirect,
  input logic [ADDR_W-1:0] target_pc,
  input logic              squash,
  input logic [31:0]       id_instr,
  input ctl_kind_t         dec_kind,
  input logic              opnd_zero
);

  // R2
  seq_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect |=> fetch_pc == $past(fetch_pc) + ADDR_W'(4));

  // R6
  redirect_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> fetch_pc == $past(target_pc));

  // R7
  squash_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    squash |=> id_instr == NOP_WORD);

  // R8
  slot_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (delay_mode && redirect) |=> id_instr == $past(fetch_instr));

  // R8
  no_squash_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    delay_mode |-> !squash);

  // R9
  ctl_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> dec_kind != CTL_NONE);

  // R5
  jump_always_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_kind == CTL_JUMP |-> redirect);

  // R3
  zero_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_kind == CTL_BR_ZERO && opnd_zero) |-> redirect);

endmodule

bind branch_resolve_unit brr_checker #(.ADDR_W(ADDR_W)) u_brr_checker (
  .clk(clk), .rst_n(rst_n), .delay_mode(delay_mode),
  .fetch_instr(fetch_instr), .fetch_pc(fetch_pc), .redirect(redirect),
  .target_pc(target_pc), .squash(squash), .id_instr(id_instr),
  .dec_kind(dec_kind), .opnd_zero(opnd_zero)
);

// File: tb/branch_resolve_unit_bench.sv
`timescale 1ns/1ps
module branch_resolve_unit_bench;

  localparam logic [31:0] BASE = 32'h0000_1000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        delay_mode = 1'b0;
  logic [31:0] fetch_instr, rs_data, fetch_pc, target_pc, id_instr;
  logic [4:0]  rs_idx;
  logic        redirect, squash;

  logic [31:0] prog [64];
  logic [31:0] regs [32];

  int checks = 0;
  int fails = 0;
  bit mon_en = 1'b0;
  bit done = 1'b0;
  logic [31:0] exp_q [$];

  branch_resolve_unit u_branch_resolve_unit (
    .clk(clk), .rst_n(rst_n), .delay_mode(delay_mode),
    .fetch_instr(fetch_instr), .rs_data(rs_data), .fetch_pc(fetch_pc),
    .rs_idx(rs_idx), .redirect(redirect), .target_pc(target_pc),
    .squash(squash), .id_instr(id_instr)
  );

  function automatic logic [31:0] filler(input int i);
    return {6'h08, 5'd1, 5'd2, 16'(i + 16'h100)};
  endfunction

  function automatic logic [31:0] word_at(input logic [31:0] pc);
    logic [31:0] off;
    off = pc - BASE;
    if (pc >= BASE && off < 32'd256) return prog[off[7:2]];
    return filler(999);
  endfunction

  assign fetch_instr = word_at(fetch_pc);
  assign rs_data = regs[rs_idx];

  function automatic logic [31:0] mk_br(input logic [4:0] sub, input logic [4:0] rs,
                                        input logic [15:0] imm);
    return {6'h01, rs, sub, imm};
  endfunction

  function automatic logic [31:0] mk_j(input logic [25:0] f);
    return {6'h02, f};
  endfunction

  // Independent restatement of R4: signed word count times four.
  function automatic logic [31:0] exp_br(input logic [31:0] pc4, input logic [15:0] imm);
    logic signed [15:0] s;
    s = imm;
    return pc4 + 32'(int'(s) * 4);
  endfunction

  // R5: keep the 256 MB region, replace the rest.
  function automatic logic [31:0] exp_jmp(input logic [31:0] pc4, input logic [25:0] f);
    return (pc4 & 32'hF000_0000) | (32'(f) * 4);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pops the expected fetch-address trace (R2, R6).
  always @(negedge clk) begin
    if (mon_en && exp_q.size() > 0) begin
      logic [31:0] e;
      e = exp_q.pop_front();
      check(fetch_pc == e, "R2/R6 fetch trace", fetch_pc, e);
    end
  end

  task automatic run_case(input bit mode, input logic [31:0] br, input bit tk,
                          input logic [31:0] tgt, input string req);
    logic [31:0] t4;
    for (int i = 0; i < 64; i++) prog[i] = filler(i);
    prog[2] = br;
    mon_en = 1'b0;
    exp_q.delete();
    rst_n = 1'b0;
    delay_mode = mode;
    repeat (2) @(posedge clk);
    @(negedge clk); #1;
    // R1 reset state
    check(fetch_pc == BASE, "R1 reset pc", fetch_pc, BASE);
    check(id_instr == 32'h0, "R1 reset decode slot", id_instr, 32'h0);
    check(redirect == 1'b0, "R1 reset redirect", 32'(redirect), 32'h0);
    t4 = tk ? tgt : BASE + 32'd16;
    exp_q.push_back(BASE + 32'd4);
    exp_q.push_back(BASE + 32'd8);
    exp_q.push_back(BASE + 32'd12);
    exp_q.push_back(t4);
    exp_q.push_back(t4 + 32'd4);
    rst_n = 1'b1;
    mon_en = 1'b1;
    @(negedge clk); #2;
    @(negedge clk); #2;
    // R9: an ordinary instruction in decode
    check(redirect == 1'b0, "R9 filler no redirect", 32'(redirect), 32'h0);
    @(negedge clk); #2;
    // R6 branch in decode
    check(redirect == tk, {req, " R6 redirect"}, 32'(redirect), 32'(tk));
    check(squash == (tk && !mode), mode ? "R8 squash" : "R7 squash",
          32'(squash), 32'(tk && !mode));
    check(rs_idx == br[25:21], "R3 rs_idx", 32'(rs_idx), 32'(br[25:21]));
    if (tk) check(target_pc == tgt, {req, " target"}, target_pc, tgt);
    @(negedge clk); #2;
    if (tk && !mode) check(id_instr == 32'h0, "R7 squashed slot", id_instr, 32'h0);
    else check(id_instr == prog[3], "R8 successor kept", id_instr, prog[3]);
    @(negedge clk); #2;
    check(exp_q.size() == 0, "R2 trace drained", 32'(exp_q.size()), 32'h0);
  endtask

  initial begin
    for (int r = 0; r < 32; r++) regs[r] = 32'h11 * r + 32'h5;
    regs[0] = 32'h0;
    regs[3] = 32'h0;
    regs[4] = 32'hFFFF_FFFF;
    regs[5] = 32'h0;
    regs[6] = 32'h8000_0000;
    regs[7] = 32'h7;
    for (int m = 0; m < 2; m++) begin
      bit md;
      md = (m == 1);
      // R3 R4 zero test taken, forward offset
      run_case(md, mk_br(5'h00, 5'd3, 16'd5), 1'b1, exp_br(BASE + 32'd12, 16'd5), "R4");
      // R3 small non-zero operand, not taken
      run_case(md, mk_br(5'h00, 5'd7, 16'd5), 1'b0, 32'h0, "R3");
      // R3 only the top operand bit set, not taken
      run_case(md, mk_br(5'h00, 5'd6, 16'd9), 1'b0, 32'h0, "R3");
      // R4 non-zero test taken, backward offset
      run_case(md, mk_br(5'h01, 5'd4, 16'hFFFD), 1'b1,
               exp_br(BASE + 32'd12, 16'hFFFD), "R4");
      // R3 non-zero test with zero operand
      run_case(md, mk_br(5'h01, 5'd5, 16'd2), 1'b0, 32'h0, "R3");
      // R5 jump
      run_case(md, mk_j(26'h410), 1'b1, exp_jmp(BASE + 32'd12, 26'h410), "R5");
      // R9 unused sub-code with zero operand
      run_case(md, mk_br(5'h03, 5'd0, 16'd4), 1'b0, 32'h0, "R9");
    end
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule